// File: doc/BRIEF.md
# Two-Way Coherent Cache Tag Controller

This block keeps the tags, coherence state and replacement bit for a two-way set-associative write-back data cache. A processor-side lookup port presents an address together with the direction of the access, the write policy to use if the access allocates a line, and two cacheability controls: a page-level disable bit and an active-low external enable. The block reports, in the same cycle, whether the access hits, in which way, and the line's current state. It also reports whether a write must go out to the bus. On an accepted access it updates the line state and the replacement bit.

A second port lets an external bus master probe the cache. A probe that finds a modified line first asks for that line to be written back. The line then drops to shared, or to invalid when the probe carries the invalidate flag. Read misses that are allowed to allocate run as handshakes with an external requester. If the chosen victim is modified, a writeback request comes first, and a fill request follows it. The data array and the bus timing live outside this block.

Top module: `mesiTagUnit`

## Requirements
- R1: After reset every line is Invalid and every replacement bit is 0. No writeback or fill request is raised, and both ports are ready.
- R2: The address is split into bits [4:0] offset, [11:5] set index and [31:12] tag. A lookup hits only when a way in the indexed set holds a non-Invalid state, a matching tag and a correct parity bit. lkHit, lkWay and lkState are combinational, with state codes Invalid=00, Shared=01, Exclusive=10, Modified=11. lkState reads 00 on a miss.
- R3: An accepted read miss starts an allocation only when lkPageNoCache is 0 and lkCacheEnN is 0. Otherwise no request is raised. An accepted write miss asserts lkBusWrite and allocates nothing.
- R4: The victim is the lowest-numbered Invalid way. When neither way is Invalid, the victim is the way named by the set's replacement bit. A read or write hit sets that bit to the other way, and a completed fill does the same.
- R5: When a fill completes, the line is written with its tag and enters Exclusive. It enters Shared instead if fillShared is 1 or if the access asked for write-through.
- R6: A write hit behaves as follows. A write-back Exclusive line becomes Modified with lkBusWrite 0. A Modified line stays Modified. A Shared line stays Shared with lkBusWrite 1. A write-through line goes to Shared with lkBusWrite 1 and never becomes Modified.
- R7: When the victim is Modified, wbReq rises with the victim's line address and holds until wbAck. Only then does fillReq rise, with the missed line's address. The two requests are never high together.
- R8: A probe that hits a Modified line raises wbReq with the probed line address on the next cycle and holds it until wbAck. The line stays Modified until then. It then becomes Shared, or Invalid if the invalidate flag was set.
- R9: A probe that hits a non-Modified line moves it to Invalid when snpInv is 1 and to Shared otherwise, without any writeback. A probe that misses changes nothing.
- R10: A fill writes even parity over the tag, inverted when fillParityFlip is 1 during fillAck. A tag match with bad parity gives lkParityErr 1 and is treated as a miss.
- R11: A probe and a lookup in the same set in the same cycle stall the lookup (lkReady 0). Lookups to other sets proceed. While a writeback or fill is pending, both lkReady and snpReady are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup present |
| lkAddr | input | 32 | Lookup byte address |
| lkWrite | input | 1 | 1 = write, 0 = read |
| lkWriteThru | input | 1 | Policy for a line allocated by this access |
| lkPageNoCache | input | 1 | Page-level cache disable |
| lkCacheEnN | input | 1 | External cache enable, active low |
| lkReady | output | 1 | Lookup accepted this cycle when valid |
| lkHit | output | 1 | Lookup hit |
| lkWay | output | 1 | Hitting way |
| lkState | output | 2 | State of hitting line |
| lkParityErr | output | 1 | Tag parity mismatch on a match |
| lkBusWrite | output | 1 | Accepted write must go to the bus |
| snpValid | input | 1 | Probe present |
| snpAddr | input | 32 | Probe byte address |
| snpInv | input | 1 | Probe invalidates |
| snpReady | output | 1 | Probe accepted when valid |
| snpHit | output | 1 | Probe hit |
| snpState | output | 2 | State of the probed line |
| wbReq | output | 1 | Writeback request |
| wbAddr | output | 32 | Line address to write back |
| wbAck | input | 1 | Writeback done |
| fillReq | output | 1 | Fill request |
| fillAddr | output | 32 | Line address to fill |
| fillAck | input | 1 | Fill done |
| fillShared | input | 1 | Filled line is held elsewhere |
| fillParityFlip | input | 1 | Inverts stored parity on this fill |

## Verification
The hardest case to reach is an allocation whose victim is Modified. It needs both ways of one set to be valid, the victim way to have been dirtied by a write hit, and the replacement bit to be steered back onto that way by a later hit on the other way. The bench first fills every set through a sweep, so each set has a known layout. It then runs a fixed write, write, read-miss sequence on one chosen set and checks the writeback address, and the fill that follows, cycle by cycle. Modified lines hit by probes are built in the same way from a prior write hit.

// File: rtl/mesiTagPkg.sv
package mesiTagPkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  lkStWe;
    mesi_t lkStVal;
    logic  lkLruWe;
    logic  snpStWe;
    logic  snpLatch;
    logic  snpDoneWe;
    mesi_t snpStVal;
    logic  missLatch;
    logic  fillWe;
    mesi_t fillStVal;
    logic  wbFromSnp;
  } strobe_t;
endpackage

// File: rtl/mesiTagPath.sv
module mesiTagPath
  import mesiTagPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWriteThru,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              fillParityFlip,
  input  strobe_t           stb,
  output logic              lkHit,
  output logic              lkWay,
  output mesi_t             lkState,
  output logic              lkWt,
  output logic              lkParErr,
  output mesi_t             victimState,
  output logic              snpHit,
  output mesi_t             snpState,
  output logic              sameSet,
  output logic              pendWt,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [ADDR_W-1:0] fillAddr
);
  localparam int SETS  = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
  localparam int WAYS  = 2;

  logic [TAG_W-1:0] tagArr [WAYS][SETS];
  logic             parArr [WAYS][SETS];
  logic             wtArr  [WAYS][SETS];
  mesi_t            stArr  [WAYS][SETS];
  logic             lruArr [SETS];

  logic [INDEX_W-1:0] lkIdx, snpIdx;
  logic [TAG_W-1:0]   lkTag, snpTag;
  assign lkIdx  = lkAddr[OFFSET_W +: INDEX_W];
  assign lkTag  = lkAddr[ADDR_W-1 -: TAG_W];
  assign snpIdx = snpAddr[OFFSET_W +: INDEX_W];
  assign snpTag = snpAddr[ADDR_W-1 -: TAG_W];
  assign sameSet = (lkIdx == snpIdx);

  logic [WAYS-1:0] lkHitW, lkPerrW, snpHitW;

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic lkMatch, lkParOk, snpMatch, snpParOk;
    assign lkMatch  = (stArr[w][lkIdx] != ST_I) && (tagArr[w][lkIdx] == lkTag);
    assign lkParOk  = ((^tagArr[w][lkIdx]) == parArr[w][lkIdx]);
    assign snpMatch = (stArr[w][snpIdx] != ST_I) && (tagArr[w][snpIdx] == snpTag);
    assign snpParOk = ((^tagArr[w][snpIdx]) == parArr[w][snpIdx]);
    assign lkHitW[w]  = lkMatch & lkParOk;
    assign lkPerrW[w] = lkMatch & ~lkParOk;
    assign snpHitW[w] = snpMatch & snpParOk;
  end

  logic snpWay;
  assign lkHit    = |lkHitW;
  assign lkWay    = lkHitW[1];
  assign lkState  = lkHit ? stArr[lkWay][lkIdx] : ST_I;
  assign lkWt     = wtArr[lkWay][lkIdx];
  assign lkParErr = |lkPerrW;
  assign snpHit   = |snpHitW;
  assign snpWay   = snpHitW[1];
  assign snpState = snpHit ? stArr[snpWay][snpIdx] : ST_I;

  // victim choice: invalid way first, then the replacement bit
  logic victimWay;
  always_comb begin
    if (stArr[0][lkIdx] == ST_I)      victimWay = 1'b0;
    else if (stArr[1][lkIdx] == ST_I) victimWay = 1'b1;
    else                              victimWay = lruArr[lkIdx];
  end
  assign victimState = stArr[victimWay][lkIdx];

  // pending miss and pending probe context
  logic [INDEX_W-1:0] pIdx, sIdx;
  logic [TAG_W-1:0]   pTag, pVicTag, sTag;
  logic               pWay, pWtQ, sWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pIdx <= '0; pTag <= '0; pVicTag <= '0; pWay <= 1'b0; pWtQ <= 1'b0;
      sIdx <= '0; sTag <= '0; sWay <= 1'b0;
    end else begin
      if (stb.missLatch) begin
        pIdx    <= lkIdx;
        pTag    <= lkTag;
        pWay    <= victimWay;
        pVicTag <= tagArr[victimWay][lkIdx];
        pWtQ    <= lkWriteThru;
      end
      if (stb.snpLatch) begin
        sIdx <= snpIdx;
        sTag <= snpTag;
        sWay <= snpWay;
      end
    end
  end

  assign pendWt   = pWtQ;
  assign fillAddr = {pTag, pIdx, {OFFSET_W{1'b0}}};
  assign wbAddr   = stb.wbFromSnp ? {sTag, sIdx, {OFFSET_W{1'b0}}}
                                  : {pVicTag, pIdx, {OFFSET_W{1'b0}}};

  // state and replacement storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruArr[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) stArr[w][s] <= ST_I;
      end
    end else begin
      if (stb.lkStWe)    stArr[lkWay][lkIdx]   <= stb.lkStVal;
      if (stb.lkLruWe)   lruArr[lkIdx]         <= ~lkWay;
      if (stb.snpStWe)   stArr[snpWay][snpIdx] <= stb.snpStVal;
      if (stb.snpDoneWe) stArr[sWay][sIdx]     <= stb.snpStVal;
      if (stb.fillWe) begin
        stArr[pWay][pIdx] <= stb.fillStVal;
        lruArr[pIdx]      <= ~pWay;
      end
    end
  end

  // tag storage, written only by fills
  always_ff @(posedge clk) begin
    if (stb.fillWe) begin
      tagArr[pWay][pIdx] <= pTag;
      parArr[pWay][pIdx] <= (^pTag) ^ fillParityFlip;
      wtArr[pWay][pIdx]  <= pWtQ;
    end
  end
endmodule

// File: rtl/mesiTagFsm.sv
module mesiTagFsm
  import mesiTagPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lkValid,
  input  logic    lkWrite,
  input  logic    lkPageNoCache,
  input  logic    lkCacheEnN,
  input  logic    lkHit,
  input  mesi_t   lkState,
  input  logic    lkWt,
  input  mesi_t   victimState,
  input  logic    snpValid,
  input  logic    snpInv,
  input  logic    snpHit,
  input  mesi_t   snpState,
  input  logic    sameSet,
  input  logic    pendWt,
  input  logic    wbAck,
  input  logic    fillAck,
  input  logic    fillShared,
  output strobe_t stb,
  output logic    lkReady,
  output logic    snpReady,
  output logic    lkBusWrite,
  output logic    wbReq,
  output logic    fillReq
);
  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_FILL, F_SNPWB} fsm_t;
  fsm_t state, nextState;
  logic snpInvQ;

  logic idle, snpAcc, snpNeedWb, lkAcc, fillOk;
  assign idle      = (state == F_IDLE);
  assign snpReady  = idle;
  assign snpAcc    = snpValid & idle;
  assign snpNeedWb = snpAcc & snpHit & (snpState == ST_M);
  assign lkReady   = idle & ~(snpValid & (sameSet | snpNeedWb));
  assign lkAcc     = lkValid & lkReady;
  assign fillOk    = ~lkPageNoCache & ~lkCacheEnN;
  assign wbReq     = (state == F_EVICT) | (state == F_SNPWB);
  assign fillReq   = (state == F_FILL);

  always_comb begin
    stb        = '0;
    nextState  = state;
    lkBusWrite = 1'b0;
    unique case (state)
      F_IDLE: begin
        if (snpAcc && snpHit) begin
          if (snpState == ST_M) begin
            stb.snpLatch = 1'b1;
            nextState    = F_SNPWB;
          end else begin
            stb.snpStWe  = 1'b1;
            stb.snpStVal = snpInv ? ST_I : ST_S;
          end
        end
        if (lkAcc) begin
          if (lkHit) begin
            stb.lkLruWe = 1'b1;
            if (lkWrite) begin
              if (lkWt) begin
                stb.lkStWe  = 1'b1;
                stb.lkStVal = ST_S;
                lkBusWrite  = 1'b1;
              end else if (lkState == ST_S) begin
                lkBusWrite  = 1'b1;
              end else if (lkState == ST_E) begin
                stb.lkStWe  = 1'b1;
                stb.lkStVal = ST_M;
              end
            end
          end else if (lkWrite) begin
            lkBusWrite = 1'b1;
          end else if (fillOk) begin
            stb.missLatch = 1'b1;
            nextState     = (victimState == ST_M) ? F_EVICT : F_FILL;
          end
        end
      end
      F_EVICT: begin
        if (wbAck) nextState = F_FILL;
      end
      F_FILL: begin
        if (fillAck) begin
          stb.fillWe    = 1'b1;
          stb.fillStVal = (pendWt | fillShared) ? ST_S : ST_E;
          nextState     = F_IDLE;
        end
      end
      F_SNPWB: begin
        stb.wbFromSnp = 1'b1;
        if (wbAck) begin
          stb.snpDoneWe = 1'b1;
          stb.snpStVal  = snpInvQ ? ST_I : ST_S;
          nextState     = F_IDLE;
        end
      end
      default: nextState = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= F_IDLE;
      snpInvQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.snpLatch) snpInvQ <= snpInv;
    end
  end
endmodule

// File: rtl/mesiTagUnit.sv
module mesiTagUnit
  import mesiTagPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkWrite,
  input  logic              lkWriteThru,
  input  logic              lkPageNoCache,
  input  logic              lkCacheEnN,
  output logic              lkReady,
  output logic              lkHit,
  output logic              lkWay,
  output logic [1:0]        lkState,
  output logic              lkParityErr,
  output logic              lkBusWrite,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpInv,
  output logic              snpReady,
  output logic              snpHit,
  output logic [1:0]        snpState,
  output logic              wbReq,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAck,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillAck,
  input  logic              fillShared,
  input  logic              fillParityFlip
);
  strobe_t stb;
  mesi_t   lkStateE, snpStateE, victimState;
  logic    lkWt, sameSet, pendWt;

  mesiTagPath #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) uPath (
    .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkWriteThru(lkWriteThru),
    .snpAddr(snpAddr), .fillParityFlip(fillParityFlip), .stb(stb),
    .lkHit(lkHit), .lkWay(lkWay), .lkState(lkStateE), .lkWt(lkWt),
    .lkParErr(lkParityErr), .victimState(victimState), .snpHit(snpHit),
    .snpState(snpStateE), .sameSet(sameSet), .pendWt(pendWt),
    .wbAddr(wbAddr), .fillAddr(fillAddr)
  );

  mesiTagFsm uFsm (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .lkPageNoCache(lkPageNoCache), .lkCacheEnN(lkCacheEnN), .lkHit(lkHit),
    .lkState(lkStateE), .lkWt(lkWt), .victimState(victimState),
    .snpValid(snpValid), .snpInv(snpInv), .snpHit(snpHit),
    .snpState(snpStateE), .sameSet(sameSet), .pendWt(pendWt),
    .wbAck(wbAck), .fillAck(fillAck), .fillShared(fillShared), .stb(stb),
    .lkReady(lkReady), .snpReady(snpReady), .lkBusWrite(lkBusWrite),
    .wbReq(wbReq), .fillReq(fillReq)
  );

  assign lkState  = lkStateE;
  assign snpState = snpStateE;
endmodule

// File: rtl/mesiTagChecker.sv
module mesiTagChecker #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkWrite,
  input logic              lkPageNoCache,
  input logic              lkCacheEnN,
  input logic              lkReady,
  input logic              lkHit,
  input logic [1:0]        lkState,
  input logic              lkParityErr,
  input logic              snpValid,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpInv,
  input logic              snpReady,
  input logic              snpHit,
  input logic [1:0]        snpState,
  input logic              wbReq,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              wbAck,
  input logic              fillReq
);
  logic sameIdx;
  assign sameIdx = lkAddr[OFFSET_W +: INDEX_W] == snpAddr[OFFSET_W +: INDEX_W];

  assert_hit_state_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkHit) |-> (lkState != 2'b00));

  assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && !lkHit && !lkWrite && (lkPageNoCache || lkCacheEnN))
      |=> (!fillReq && !wbReq));

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wbReq && fillReq));

  assert_snoop_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpReady && snpHit && snpState == 2'b11)
      |=> (wbReq && wbAddr == (($past(snpAddr) >> OFFSET_W) << OFFSET_W)));

  assert_snoop_inv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpAddr == $past(snpAddr) &&
     $past(snpValid && snpReady && snpInv && snpHit && snpState != 2'b11))
      |-> !snpHit);

  assert_parity_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkParityErr) |-> !lkHit);

  assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpReady && lkValid && sameIdx) |-> !lkReady);

  assert_busy_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq || fillReq) |-> (!lkReady && !snpReady));
endmodule

bind mesiTagUnit mesiTagChecker #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite),
  .lkPageNoCache(lkPageNoCache), .lkCacheEnN(lkCacheEnN), .lkReady(lkReady),
  .lkHit(lkHit), .lkState(lkState), .lkParityErr(lkParityErr),
  .snpValid(snpValid), .snpAddr(snpAddr), .snpInv(snpInv), .snpReady(snpReady),
  .snpHit(snpHit), .snpState(snpState), .wbReq(wbReq), .wbAddr(wbAddr),
  .wbAck(wbAck), .fillReq(fillReq)
);

// File: tb/sim_mesiTagUnit.sv
module sim_mesiTagUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        lkValid = 0, lkWrite = 0, lkWriteThru = 0, lkPageNoCache = 0, lkCacheEnN = 0;
  logic [31:0] lkAddr = 0;
  logic        lkReady, lkHit, lkWay, lkParityErr, lkBusWrite;
  logic [1:0]  lkState;
  logic        snpValid = 0, snpInv = 0;
  logic [31:0] snpAddr = 0;
  logic        snpReady, snpHit;
  logic [1:0]  snpState;
  logic        wbReq, fillReq;
  logic [31:0] wbAddr, fillAddr;
  logic        wbAck = 0, fillAck = 0, fillShared = 0, fillParityFlip = 0;

  mesiTagUnit u0 (.*);

  int checks = 0;
  int errors = 0;
  logic rHit, rWay, rPerr, rBw, rRdy, sHit;
  logic [1:0] rSt, sSt;

  localparam logic [1:0] I_ = 2'b00, S_ = 2'b01, E_ = 2'b10, M_ = 2'b11;

  function automatic logic [31:0] mk(input int t, input int s);
    return {t[19:0], s[6:0], 5'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lkOp(input logic [31:0] a, input logic wr, input logic wt,
                      input logic pcd, input logic kenN);
    @(negedge clk);
    lkValid = 1; lkAddr = a; lkWrite = wr; lkWriteThru = wt;
    lkPageNoCache = pcd; lkCacheEnN = kenN;
    #1;
    rHit = lkHit; rWay = lkWay; rSt = lkState; rPerr = lkParityErr;
    rBw = lkBusWrite; rRdy = lkReady;
    @(posedge clk); #1;
    lkValid = 0; lkWrite = 0; lkWriteThru = 0;
  endtask

  // probe without allocation
  task automatic probe(input logic [31:0] a);
    lkOp(a, 0, 0, 1, 0);
  endtask

  task automatic doFill(input logic sh, input logic flip, input logic [31:0] expAddr, input string req);
    chk({req, " fillReq"}, fillReq, 1);
    chk({req, " fillAddr"}, fillAddr, expAddr);
    @(negedge clk);
    fillAck = 1; fillShared = sh; fillParityFlip = flip;
    @(posedge clk); #1;
    fillAck = 0; fillShared = 0; fillParityFlip = 0;
    chk({req, " fill done"}, fillReq, 0);
  endtask

  task automatic wbDone();
    @(negedge clk); wbAck = 1;
    @(posedge clk); #1; wbAck = 0;
  endtask

  task automatic snp(input logic [31:0] a, input logic inv);
    @(negedge clk);
    snpValid = 1; snpAddr = a; snpInv = inv;
    #1; sHit = snpHit; sSt = snpState;
    @(posedge clk); #1;
    snpValid = 0; snpInv = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk("R1 lkReady", lkReady, 1);
    chk("R1 snpReady", snpReady, 1);
    chk("R1 wbReq", wbReq, 0);
    chk("R1 fillReq", fillReq, 0);

    // sweep all sets: two fills per set (R1 miss, R4 invalid way first, R5 state)
    for (int s = 0; s < 128; s++) begin
      lkOp(mk(1, s), 0, 0, 0, 0);
      chk("R1 empty miss", rHit, 0);
      doFill(s[0], 0, mk(1, s), "R5");
      lkOp(mk(2, s), 0, 0, 0, 0);
      chk("R2 other tag miss", rHit, 0);
      doFill(0, 0, mk(2, s), "R5");
      probe(mk(1, s));
      chk("R4 way0 first", {rHit, rWay}, 2'b10);
      chk("R5 fill state", rSt, s[0] ? S_ : E_);
      probe(mk(2, s));
      chk("R4 way1 second", {rHit, rWay}, 2'b11);
      chk("R2 state code", rSt, E_);
    end
    // after probes every replacement bit points at way0

    // R4 replacement: set 5, hit way0 then miss -> victim way1
    lkOp(mk(1, 5), 0, 0, 0, 0);
    chk("R4 hit way0", rHit, 1);
    lkOp(mk(3, 5), 0, 0, 0, 0);
    chk("R4 no evict for clean victim", wbReq, 0);
    doFill(0, 0, mk(3, 5), "R4");
    probe(mk(2, 5)); chk("R4 old way1 gone", rHit, 0);
    probe(mk(1, 5)); chk("R4 way0 kept", {rHit, rWay}, 2'b10);
    probe(mk(3, 5)); chk("R4 new in way1", {rHit, rWay}, 2'b11);

    // R6 write hits
    lkOp(mk(1, 6), 1, 0, 0, 0);
    chk("R6 E write no bus", rBw, 0);
    probe(mk(1, 6)); chk("R6 E->M", rSt, M_);
    lkOp(mk(1, 6), 1, 0, 0, 0);
    chk("R6 M write no bus", rBw, 0);
    probe(mk(1, 6)); chk("R6 M stays", rSt, M_);
    lkOp(mk(1, 7), 1, 0, 0, 0);
    chk("R6 S write bus", rBw, 1);
    probe(mk(1, 7)); chk("R6 S stays", rSt, S_);

    // R5/R6 write-through line in set 8 (victim way0 by replacement bit)
    lkOp(mk(4, 8), 0, 1, 0, 0);
    doFill(0, 0, mk(4, 8), "R5");
    probe(mk(4, 8)); chk("R5 write-through fill shared", {rHit, rWay, rSt}, {2'b10, S_});
    lkOp(mk(4, 8), 1, 0, 0, 0);
    chk("R6 write-through bus", rBw, 1);
    probe(mk(4, 8)); chk("R6 write-through never M", rSt, S_);

    // R7 eviction of a modified victim in set 9
    lkOp(mk(2, 9), 1, 0, 0, 0);
    chk("R6 way1 E->M quiet", rBw, 0);
    lkOp(mk(1, 9), 1, 0, 0, 0);
    chk("R6 way0 S bus", rBw, 1);
    lkOp(mk(5, 9), 0, 0, 0, 0);
    chk("R7 wbReq", wbReq, 1);
    chk("R7 wbAddr victim", wbAddr, mk(2, 9));
    chk("R7 no fill yet", fillReq, 0);
    chk("R11 busy lkReady", lkReady, 0);
    @(posedge clk); #1;
    chk("R7 wbReq held", wbReq, 1);
    wbDone();
    chk("R7 wb dropped", wbReq, 0);
    doFill(0, 0, mk(5, 9), "R7");
    probe(mk(5, 9)); chk("R7 new line way1", {rHit, rWay, rSt}, {2'b11, E_});
    probe(mk(2, 9)); chk("R7 evicted miss", rHit, 0);

    // R3 fill gating on set 10
    for (int c = 1; c < 4; c++) begin
      lkOp(mk(6, 10), 0, 0, c[0], c[1]);
      chk("R3 miss", rHit, 0);
      chk("R3 no fill", fillReq, 0);
      chk("R3 no wb", wbReq, 0);
      chk("R3 still ready", lkReady, 1);
    end
    lkOp(mk(7, 10), 1, 0, 0, 0);
    chk("R3 write miss bus", rBw, 1);
    chk("R3 write miss no fill", fillReq, 0);
    probe(mk(7, 10)); chk("R3 no allocate", rHit, 0);

    // R9 probes on clean lines, set 11
    snp(mk(2, 11), 0);
    chk("R9 probe hit E", {sHit, sSt}, {1'b1, E_});
    chk("R9 no wb", wbReq, 0);
    probe(mk(2, 11)); chk("R9 E->S", rSt, S_);
    snp(mk(1, 11), 1);
    chk("R9 probe hit S", {sHit, sSt}, {1'b1, S_});
    probe(mk(1, 11)); chk("R9 invalidated", rHit, 0);
    snp(mk(9, 12), 1);
    chk("R9 probe miss", sHit, 0);
    chk("R9 miss no wb", wbReq, 0);
    probe(mk(1, 12)); chk("R9 miss no effect", {rHit, rSt}, {1'b1, E_});

    // R8 probe on modified line, set 6 way0
    snp(mk(1, 6), 0);
    chk("R8 probe sees M", sSt, M_);
    chk("R8 wbReq", wbReq, 1);
    chk("R8 wbAddr", wbAddr, mk(1, 6));
    chk("R11 snpReady busy", snpReady, 0);
    @(posedge clk); #1;
    chk("R8 wb held", wbReq, 1);
    wbDone();
    probe(mk(1, 6)); chk("R8 M->S", {rHit, rSt}, {1'b1, S_});
    lkOp(mk(5, 9), 1, 0, 0, 0);
    snp(mk(5, 9), 1);
    chk("R8 inv probe sees M", sSt, M_);
    chk("R8 inv wbAddr", wbAddr, mk(5, 9));
    wbDone();
    probe(mk(5, 9)); chk("R8 M->I", rHit, 0);

    // R10 parity injection, set 20 victim way0
    lkOp(mk(8, 20), 0, 0, 0, 0);
    doFill(0, 1, mk(8, 20), "R10");
    probe(mk(8, 20));
    chk("R10 parity err", rPerr, 1);
    chk("R10 treated as miss", rHit, 0);
    probe(mk(2, 20));
    chk("R10 clean way", {rHit, rPerr}, 2'b10);

    // R11 same-set priority
    @(negedge clk);
    lkValid = 1; lkAddr = mk(2, 30); snpValid = 1; snpAddr = mk(9, 30);
    #0.5; chk("R11 same set stall", lkReady, 0);
    snpAddr = mk(9, 31);
    #0.5; chk("R11 other set proceeds", lkReady, 1);
    lkValid = 0; snpValid = 0;
    @(posedge clk); #1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule